// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Commands

This block is a watchdog timer. Once started, it counts pulses on a single tick input, which stands in for whichever clock source is selected elsewhere. If software does not restart the count before a programmed limit, the watchdog raises an interrupt request and/or a reset request. In windowed mode it also treats a restart that arrives too soon as a fault. Each output has its own enable, and four sticky flags record which condition fired.

Starting, stopping and restarting the counter are guarded. Each one takes an ordered pair of byte writes to a command port. Any other write to that port between the two bytes breaks the pair. Configuration sits in a control word, which holds four 4-bit threshold selectors, the window switch, the two output enables and the flags. A separate 3-bit word records the chosen tick source.

Top module: `wwdt_core`

## Requirements
- R1: After a synchronous reset, the control word reads all zeros, the counter is stopped, `clk_src` is 0, and `irq` and `rst_req` are low.
- R2: A command write of 0xFE followed directly by 0xED starts the counter. While the counter is stopped it holds at zero, so no amount of ticks sets any flag.
- R3: A command write of 0xDE followed directly by 0xAD stops the counter and returns it to zero.
- R4: A command write of 0xA5 followed directly by 0x5A restarts the count from zero.
- R5: Any other command write between the two bytes of a pair cancels the pair, and a single byte of a pair has no effect.
- R6: Selector n picks a period of 2^(CNT_W-1-n) ticks, and the period is 1 tick when n is CNT_W-1 or more. The interrupt selector is bits 3:0 and the reset selector is bits 7:4. While running, the interrupt-late flag (bit 20) and the reset-late flag (bit 22) set one clock after the count reaches the period of their own selector.
- R7: With window bit 16 set, a restart completed while running with the count below the early period sets the interrupt-early flag (bit 21) if bit 17 is set, and the reset-early flag (bit 23) if bit 18 is set. The early interrupt selector is bits 11:8 and the early reset selector is bits 15:12. The counter restarts anyway. With bit 16 clear, early restarts set no flag.
- R8: The flags are sticky. A control write clears a flag whose data bit is 0 and leaves it unchanged when the data bit is 1. A flag that is set in the same cycle as a clear stays set.
- R9: `irq` is high while flag bit 20 or 21 is set and enable bit 17 is 1. `rst_req` is high while flag bit 22 or 23 is set and enable bit 18 is 1.
- R10: A write to register 2 stores data bits 2:0 as `clk_src`, and the upper data bits are ignored.
- R11: Control bit 19 reads 1 while the counter runs. A control write cannot change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the selected tick source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 command, 2 tick source |
| wr_data | input | 32 | Write data (the command port uses bits 7:0) |
| ctrl_q | output | 32 | Control word readback: selectors, enables, run bit, flags |
| clk_src | output | 3 | Stored tick-source selector |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request |

## Verification
The bench sweeps the late selector across the short-period range, including selectors that clamp to one tick. For each one it checks that no flag appears one tick before the period and that the flag appears at the period; an off-by-one compare or a wrong exponent shows up as a flag that fires one step early or late. A separate sweep restarts the counter after 0 through 6 ticks against an early period of 4. A design that inverted or shifted the early compare would flag the wrong restarts, and so would one that checked early restarts without the window bit. Broken key pairs, lone bytes, ticks while stopped and write-one-to-keep flag semantics are each driven directly: a lax key decoder would restart or stop the counter when it should not, and the late flag would then appear at the wrong time.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    // register select codes
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_SRC  = 2'd2;

    // command indices
    localparam int CMD_FEED  = 0;
    localparam int CMD_START = 1;
    localparam int CMD_STOP  = 2;
    localparam int NUM_CMDS  = 3;

    // key bytes, first and second of each pair, indexed by command
    localparam logic [NUM_CMDS-1:0][7:0] KEY_LEAD  = {8'hDE, 8'hFE, 8'hA5};
    localparam logic [NUM_CMDS-1:0][7:0] KEY_TRAIL = {8'hAD, 8'hED, 8'h5A};

    // control word bit positions
    localparam int CFG_W    = 19;
    localparam int RUN_BIT  = 19;
    localparam int FLAG_LSB = 20;

    typedef struct packed {
        logic       rst_en;
        logic       irq_en;
        logic       win;
        logic [3:0] rst_early;
        logic [3:0] int_early;
        logic [3:0] rst_late;
        logic [3:0] int_late;
    } cfg_t;

    typedef struct packed {
        logic rst_early;
        logic rst_late;
        logic int_early;
        logic int_late;
    } flags_t;

    // hit vector order
    localparam int HIT_INT_LATE  = 0;
    localparam int HIT_RST_LATE  = 1;
    localparam int HIT_INT_EARLY = 2;
    localparam int HIT_RST_EARLY = 3;

endpackage

// File: rtl/wwdt_key_match.sv
module wwdt_key_match #(
    parameter logic [7:0] LEAD  = 8'h00,
    parameter logic [7:0] TRAIL = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    output logic       fire
);
    logic armed_q;

    assign fire = cmd_wr && armed_q && (cmd_byte == TRAIL);

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (cmd_wr)
            armed_q <= (cmd_byte == LEAD);
    end
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic             running
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (stop) begin
            cnt     <= '0;
            running <= 1'b0;
        end else begin
            if (start)
                running <= 1'b1;
            if (restart)
                cnt <= '0;
            else if (running && tick && (cnt != '1))
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wwdt_thresh.sv
module wwdt_thresh #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [3:0][3:0]  sel,
    output logic [3:0]       hit
);
    localparam int TOP_EXP = CNT_W - 1;

    for (genvar i = 0; i < 4; i++) begin : g_cmp
        always_comb begin
            int e;
            if (int'(sel[i]) >= TOP_EXP)
                e = 0;
            else
                e = TOP_EXP - int'(sel[i]);
            hit[i] = (cnt >> e) != '0;
        end
    end
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] ctrl_q,
    output logic [2:0]  clk_src,
    output logic        irq,
    output logic        rst_req
);
    cfg_t                cfg_q;
    flags_t              flags_q;
    flags_t              flags_set;
    logic [NUM_CMDS-1:0] fire;
    logic [CNT_W-1:0]    cnt_q;
    logic                running;
    logic [3:0]          hit;
    logic                ctrl_wr;
    logic                cmd_wr;
    logic                early_feed;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign cmd_wr  = wr_en && (wr_sel == SEL_CMD);

    for (genvar k = 0; k < NUM_CMDS; k++) begin : g_key
        wwdt_key_match #(
            .LEAD  (KEY_LEAD[k]),
            .TRAIL (KEY_TRAIL[k])
        ) u_key (
            .clk      (clk),
            .rst      (rst),
            .cmd_wr   (cmd_wr),
            .cmd_byte (wr_data[7:0]),
            .fire     (fire[k])
        );
    end

    wwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (fire[CMD_START]),
        .stop    (fire[CMD_STOP]),
        .restart (fire[CMD_FEED]),
        .cnt     (cnt_q),
        .running (running)
    );

    wwdt_thresh #(.CNT_W(CNT_W)) u_thr (
        .cnt (cnt_q),
        .sel ({cfg_q.rst_early, cfg_q.int_early, cfg_q.rst_late, cfg_q.int_late}),
        .hit (hit)
    );

    assign early_feed = fire[CMD_FEED] && running && cfg_q.win;

    always_comb begin
        flags_set.int_late  = running && hit[HIT_INT_LATE];
        flags_set.rst_late  = running && hit[HIT_RST_LATE];
        flags_set.int_early = early_feed && cfg_q.irq_en && !hit[HIT_INT_EARLY];
        flags_set.rst_early = early_feed && cfg_q.rst_en && !hit[HIT_RST_EARLY];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            flags_q <= '0;
            clk_src <= '0;
        end else begin
            if (ctrl_wr) begin
                cfg_q   <= cfg_t'(wr_data[CFG_W-1:0]);
                flags_q <= (flags_q & flags_t'(wr_data[FLAG_LSB+3:FLAG_LSB])) | flags_set;
            end else begin
                flags_q <= flags_q | flags_set;
            end
            if (wr_en && (wr_sel == SEL_SRC))
                clk_src <= wr_data[2:0];
        end
    end

    assign ctrl_q  = {8'b0, flags_q, running, cfg_q};
    assign irq     = cfg_q.irq_en && (flags_q.int_late || flags_q.int_early);
    assign rst_req = cfg_q.rst_en && (flags_q.rst_late || flags_q.rst_early);

endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [1:0]          wr_sel,
    input logic [NUM_CMDS-1:0] fire,
    input logic [CNT_W-1:0]    cnt_q,
    input logic                running,
    input logic [3:0]          hit,
    input logic [3:0]          flags_q
);
    // stopped counter stays at zero
    p_stopped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !running |=> (cnt_q == '0));

    // stop pair halts the counter
    p_stop_halts_r3: assert property (@(posedge clk) disable iff (rst)
        fire[CMD_STOP] |=> !running);

    // restart pair zeroes the count
    p_feed_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (fire[CMD_FEED] && !fire[CMD_STOP]) |=> (cnt_q == '0));

    // late compare raises the interrupt-late flag next cycle
    p_late_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (running && hit[HIT_INT_LATE]) |=> flags_q[0]);

    // flags never drop without a control write
    p_flags_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_sel == SEL_CTRL)) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // at most one command pair completes per cycle
    p_one_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fire));
endmodule

bind wwdt_core wwdt_checker #(.CNT_W(CNT_W)) u_wwdt_checker (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .fire    (fire),
    .cnt_q   (cnt_q),
    .running (running),
    .hit     (hit),
    .flags_q (flags_q)
);

// File: tb/wwdt_core_bench.sv
module wwdt_core_bench;
    localparam int CW = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [31:0] ctrl_q;
    logic [2:0]  clk_src;
    logic        irq;
    logic        rst_req;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    wwdt_core #(.CNT_W(CW)) u_wwdt_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .clk_src (clk_src),
        .irq     (irq),
        .rst_req (rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic cmd(input logic [7:0] b);
        wr(2'd1, {24'b0, b});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // control word: selectors, window, enables; flags written as zero (clear)
    function automatic logic [31:0] mk(input int il, input int rl, input int ie,
                                       input int re, input bit win, input bit ien,
                                       input bit ren);
        mk = '0;
        mk[3:0]   = il[3:0];
        mk[7:4]   = rl[3:0];
        mk[11:8]  = ie[3:0];
        mk[15:12] = re[3:0];
        mk[16]    = win;
        mk[17]    = ien;
        mk[18]    = ren;
    endfunction

    task automatic feed();  cmd(8'hA5); cmd(8'h5A); endtask
    task automatic start(); cmd(8'hFE); cmd(8'hED); endtask
    task automatic stop();  cmd(8'hDE); cmd(8'hAD); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk("R1 ctrl", ctrl_q, 32'h0);
        chk("R1 src", {29'b0, clk_src}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);

        // R10 tick source selector
        wr(2'd2, 32'hFFFF_FFF5);
        chk("R10 src", {29'b0, clk_src}, 32'd5);

        // R2 stopped counter ignores ticks
        c = mk(10, 10, 15, 15, 0, 1, 1);
        wr(2'd0, c);
        ticks(20); idle(2);
        chk("R2 no flag while stopped", {28'b0, ctrl_q[23:20]}, 32'h0);
        chk("R11 run bit low", {31'b0, ctrl_q[19]}, 32'h0);
        wr(2'd0, c | 32'h0008_0000);
        chk("R11 run bit not writable", {31'b0, ctrl_q[19]}, 32'h0);
        start();
        chk("R11 run bit high", {31'b0, ctrl_q[19]}, 32'h1);
        ticks(1); idle(2);
        chk("R2 count held at zero", {28'b0, ctrl_q[23:20]}, 32'h0);
        ticks(1); idle(2);
        chk("R2 counting after start", {28'b0, ctrl_q[23:20]}, 32'h5);

        // R6 late sweep, R4 restart, R9 outputs
        for (int n = 6; n <= 12; n++) begin
            int p;
            p = (n >= CW - 1) ? 1 : (1 << (CW - 1 - n));
            c = mk(n, n, 15, 15, 0, 1, 1);
            feed();
            wr(2'd0, c);
            chk("R8 cleared", {28'b0, ctrl_q[23:20]}, 32'h0);
            if (p > 1) begin
                ticks(p - 1); idle(2);
                chk("R6 below period", {28'b0, ctrl_q[23:20]}, 32'h0);
            end
            ticks(1); idle(2);
            chk("R6 at period", {28'b0, ctrl_q[23:20]}, 32'h5);
            chk("R9 irq", {31'b0, irq}, 32'h1);
            chk("R9 rst_req", {31'b0, rst_req}, 32'h1);
        end

        // R8 write 1 keeps flags
        wr(2'd0, mk(6, 6, 15, 15, 0, 1, 1) | 32'h0050_0000);
        chk("R8 keep on one", {28'b0, ctrl_q[23:20]}, 32'h5);

        // R9 gating: interrupt disabled, reset enabled
        feed();
        wr(2'd0, mk(8, 8, 15, 15, 0, 0, 1));
        ticks(8); idle(2);
        chk("R9 irq gated", {31'b0, irq}, 32'h0);
        chk("R9 rst_req on", {31'b0, rst_req}, 32'h1);
        chk("R9 flags still set", {28'b0, ctrl_q[23:20]}, 32'h5);
        wr(2'd0, mk(8, 8, 15, 15, 0, 1, 0));
        chk("R9 rst_req gated", {31'b0, rst_req}, 32'h0);

        // R4 restart delays the late flag
        c = mk(8, 8, 15, 15, 0, 1, 1);
        feed(); wr(2'd0, c);
        ticks(6); feed(); ticks(6); idle(2);
        chk("R4 restart delays late", {28'b0, ctrl_q[23:20]}, 32'h0);
        ticks(2); idle(2);
        chk("R4 late after restart", {28'b0, ctrl_q[23:20]}, 32'h5);

        // R5 broken pair
        feed(); wr(2'd0, c);
        ticks(6);
        cmd(8'hA5); cmd(8'h11); cmd(8'h5A);
        ticks(2); idle(2);
        chk("R5 broken feed ignored", {28'b0, ctrl_q[23:20]}, 32'h5);
        // R5 lone stop byte
        feed(); wr(2'd0, c);
        cmd(8'hDE); cmd(8'h00); cmd(8'hAD);
        chk("R5 lone stop byte", {31'b0, ctrl_q[19]}, 32'h1);

        // R3 stop zeroes and halts
        ticks(6);
        stop();
        chk("R3 stopped", {31'b0, ctrl_q[19]}, 32'h0);
        ticks(20); idle(2);
        chk("R3 no count while stopped", {28'b0, ctrl_q[23:20]}, 32'h0);
        start();
        ticks(7); idle(2);
        chk("R3 count restarted at zero", {28'b0, ctrl_q[23:20]}, 32'h0);

        // R7 early sweep: early period 4 (selector 9), late period 32
        for (int k = 0; k <= 6; k++) begin
            c = mk(6, 6, 9, 9, 1, 1, 1);
            feed(); wr(2'd0, c);
            ticks(k); feed(); idle(1);
            chk("R7 early int flag", {31'b0, ctrl_q[21]}, (k < 4) ? 32'h1 : 32'h0);
            chk("R7 early rst flag", {31'b0, ctrl_q[23]}, (k < 4) ? 32'h1 : 32'h0);
        end
        // R7 only enabled outputs get an early flag
        c = mk(6, 6, 9, 9, 1, 1, 0);
        feed(); wr(2'd0, c);
        ticks(1); feed(); idle(1);
        chk("R7 enabled output only", {28'b0, ctrl_q[23:20]}, 32'h2);
        // R7 no window, no early flag
        c = mk(6, 6, 9, 9, 0, 1, 1);
        feed(); wr(2'd0, c);
        ticks(1); feed(); idle(1);
        chk("R7 window off", {28'b0, ctrl_q[23:20]}, 32'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule